// File: doc/BRIEF.md
# Stereo Audio Sample Error Concealment

This block sits after the error-correction stage of a digital audio path and repairs samples that the correction stage could not fix. Left and right 16-bit signed samples arrive together on a valid strobe, and each carries its own error flag. Each channel is handled on its own. An unflagged sample passes through unchanged. An isolated flagged sample is replaced by the mean of the last good sample and the next sample. A flagged sample that belongs to a run of two or more flagged samples takes the last good value. A long run of flagged samples is forced to zero.

Each channel keeps a two-deep look-ahead pipeline, so the sample after the one being decided is always known. This gives a fixed latency of two sample periods. The output stage has a mute request. The mute can act on the next decided sample, or it can wait until the channel's signal reaches or crosses zero. A timeout bounds that wait.

Top module: `conceal_top`

## Requirements
- R1: The concealed value of sample n leaves with `out_valid` high for exactly one cycle. That cycle follows the clock edge on which sample n+2 is accepted (`in_valid` high). The first two accepted samples after reset produce no output strobe.
- R2: During and right after reset, `out_valid`, `out_l` and `out_r` are 0.
- R3: A sample whose error flag is 0 is output bit-exact.
- R4: A flagged sample is interpolated when the sample before it and the sample after it are both unflagged. The output is floor((G + X) / 2), where G is the last unflagged sample before it and X is the next sample. The sum is taken in 17-bit signed arithmetic, so it cannot overflow. G is 0 if no unflagged sample has been seen since reset.
- R5: A flagged sample is replaced by the last unflagged value (0 if none) when the sample before it is flagged or the sample after it is flagged, as long as R6 does not apply.
- R6: A flagged sample that is the MUTE_RUN-th (default 8) or later consecutive flagged sample is output as 0. This lasts until an unflagged sample arrives.
- R7: The left and right channels share no concealment state. A flag on one channel never changes the other channel's output.
- R8: With `zc_en` = 0, a sample decided on a beat where `mute_req` = 1 is output as 0 on both channels. A beat with `mute_req` = 0 releases the mute at once.
- R9: With `zc_en` = 1 and `mute_req` held, each channel keeps passing its concealed value until the first decided value that is exactly 0 or whose sign bit differs from that of the channel's previous decided value (sign taken as positive after reset). That value and every later one are output as 0 while `mute_req` stays high.
- R10: With `mute_req` held, a channel is muted no later than on the ZC_LIMIT-th (default 1024) consecutive decision beat with `mute_req` high, even if no crossing occurs.
- R11: Between accepted samples, `out_l` and `out_r` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released on the clock |
| in_valid | input | 1 | A stereo sample pair is presented this cycle |
| in_l | input | 16 | Left sample, two's complement |
| in_r | input | 16 | Right sample, two's complement |
| in_err_l | input | 1 | Left sample is uncorrectable |
| in_err_r | input | 1 | Right sample is uncorrectable |
| mute_req | input | 1 | Mute request, sampled on each accepted beat |
| zc_en | input | 1 | 1: mute waits for a zero crossing; 0: mute acts at once |
| out_valid | output | 1 | One-cycle strobe for a concealed pair |
| out_l | output | 16 | Concealed left sample |
| out_r | output | 16 | Concealed right sample |

## Verification
The bench walks flag patterns that cover these cases:
- isolated errors, pairs and triples;
- runs that cross the MUTE_RUN threshold;
- an error on the very first sample;
- neighbours at full-scale positive and negative.

A design that sums in 16 bits would wrap at full scale. A design that rounds toward zero would give 0 instead of -1 for the mean of -1 and 0. A design that interpolates the first error of a pair would not match the held value.

The mute tests cover several cases. One ramp crosses through a sign change and another through an exact zero. A constant signal must fall back to the timeout on exactly its 1024th beat. A design with an off-by-one counter would mute one sample early or late, and a design that shared state between channels would mute both channels on one channel's crossing.

// File: rtl/conceal_pkg.sv
package conceal_pkg;

  // Decision taken for the sample at the head of a lane
  typedef enum logic [1:0] {
    CM_PASS    = 2'd0,
    CM_INTERP  = 2'd1,
    CM_HOLD    = 2'd2,
    CM_ERRMUTE = 2'd3
  } cmode_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/conceal_rst_sync.sv
module conceal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/conceal_lane.sv
module conceal_lane #(
  parameter int W        = 16,
  parameter int MUTE_RUN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         dec_en,
  input  logic [W-1:0] in_d,
  input  logic         in_e,
  output logic [W-1:0] cand_o
);
  import conceal_pkg::*;

  localparam int RUN_W = $clog2(MUTE_RUN + 1);

  // look-ahead pipeline: p1 = newer (next) sample, p2 = sample under decision
  logic [W-1:0]     p1_d_q, p1_d_n, p2_d_q, p2_d_n;
  logic             p1_e_q, p1_e_n, p2_e_q, p2_e_n;
  logic [W-1:0]     good_q, good_n;
  logic [RUN_W-1:0] run_q, run_n, run_inc;
  logic [W:0]       pair_sum;
  cmode_e           mode;

  // decision for the head sample
  always_comb begin
    run_inc  = (run_q == RUN_W'(MUTE_RUN)) ? run_q : run_q + RUN_W'(1);
    pair_sum = {good_q[W-1], good_q} + {p1_d_q[W-1], p1_d_q};
    if (!p2_e_q) begin
      mode = CM_PASS;
    end else if (run_inc >= RUN_W'(MUTE_RUN)) begin
      mode = CM_ERRMUTE;
    end else if ((run_q != '0) || p1_e_q) begin
      mode = CM_HOLD;
    end else begin
      mode = CM_INTERP;
    end
    case (mode)
      CM_PASS:   cand_o = p2_d_q;
      CM_INTERP: cand_o = pair_sum[W:1];
      CM_HOLD:   cand_o = good_q;
      default:   cand_o = '0;
    endcase
  end

  // next state
  always_comb begin
    p1_d_n = p1_d_q;
    p1_e_n = p1_e_q;
    p2_d_n = p2_d_q;
    p2_e_n = p2_e_q;
    good_n = good_q;
    run_n  = run_q;
    if (shift_en) begin
      p1_d_n = in_d;
      p1_e_n = in_e;
      p2_d_n = p1_d_q;
      p2_e_n = p1_e_q;
    end
    if (dec_en) begin
      if (!p2_e_q) begin
        good_n = p2_d_q;
        run_n  = '0;
      end else begin
        run_n  = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_d_q <= '0;
      p1_e_q <= 1'b0;
      p2_d_q <= '0;
      p2_e_q <= 1'b0;
      good_q <= '0;
      run_q  <= '0;
    end else begin
      p1_d_q <= p1_d_n;
      p1_e_q <= p1_e_n;
      p2_d_q <= p2_d_n;
      p2_e_q <= p2_e_n;
      good_q <= good_n;
      run_q  <= run_n;
    end
  end

endmodule

// File: rtl/conceal_zc_gate.sv
module conceal_zc_gate #(
  parameter int W        = 16,
  parameter int ZC_LIMIT = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] cand,
  input  logic         mute_req,
  input  logic         zc_en,
  output logic [W-1:0] out_d
);

  localparam int CNT_W = (ZC_LIMIT > 2) ? $clog2(ZC_LIMIT) : 1;

  logic             muted_q, muted_n;
  logic             prev_neg_q, prev_neg_n;
  logic [CNT_W-1:0] wait_q, wait_n;
  logic [W-1:0]     out_q, out_n;
  logic             crossed;
  logic             expired;

  always_comb begin
    crossed    = (cand == '0) || (cand[W-1] != prev_neg_q);
    expired    = (wait_q == CNT_W'(ZC_LIMIT - 1));
    muted_n    = muted_q;
    prev_neg_n = prev_neg_q;
    wait_n     = wait_q;
    out_n      = out_q;
    if (fire) begin
      prev_neg_n = cand[W-1];
      if (!mute_req) begin
        muted_n = 1'b0;
        wait_n  = '0;
        out_n   = cand;
      end else if (!zc_en || muted_q || crossed || expired) begin
        muted_n = 1'b1;
        wait_n  = '0;
        out_n   = '0;
      end else begin
        wait_n  = wait_q + CNT_W'(1);
        out_n   = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muted_q    <= 1'b0;
      prev_neg_q <= 1'b0;
      wait_q     <= '0;
      out_q      <= '0;
    end else begin
      muted_q    <= muted_n;
      prev_neg_q <= prev_neg_n;
      wait_q     <= wait_n;
      out_q      <= out_n;
    end
  end

  assign out_d = out_q;

endmodule

// File: rtl/conceal_top.sv
module conceal_top #(
  parameter int W        = 16,
  parameter int MUTE_RUN = 8,
  parameter int ZC_LIMIT = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  input  logic         in_err_l,
  input  logic         in_err_r,
  input  logic         mute_req,
  input  logic         zc_en,
  output logic         out_valid,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  import conceal_pkg::*;

  localparam logic [1:0] FILL_FULL = 2'd2;

  logic         rst_int_n;
  logic [1:0]   fill_q, fill_n;
  logic         vld_q, vld_n;
  logic         dec_en;
  logic [W-1:0] ch_d    [NUM_CH];
  logic         ch_e    [NUM_CH];
  logic [W-1:0] ch_cand [NUM_CH];
  logic [W-1:0] ch_out  [NUM_CH];

  conceal_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  assign ch_d[0] = in_l;
  assign ch_d[1] = in_r;
  assign ch_e[0] = in_err_l;
  assign ch_e[1] = in_err_r;

  // pipeline fill: decisions start once two samples are held
  always_comb begin
    dec_en = in_valid && (fill_q == FILL_FULL);
    fill_n = fill_q;
    if (in_valid && (fill_q != FILL_FULL)) begin
      fill_n = fill_q + 2'd1;
    end
    vld_n = dec_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fill_q <= 2'd0;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_n;
      vld_q  <= vld_n;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    conceal_lane #(
      .W        (W),
      .MUTE_RUN (MUTE_RUN)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .shift_en (in_valid),
      .dec_en   (dec_en),
      .in_d     (ch_d[c]),
      .in_e     (ch_e[c]),
      .cand_o   (ch_cand[c])
    );

    conceal_zc_gate #(
      .W        (W),
      .ZC_LIMIT (ZC_LIMIT)
    ) u_gate (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .fire     (dec_en),
      .cand     (ch_cand[c]),
      .mute_req (mute_req),
      .zc_en    (zc_en),
      .out_d    (ch_out[c])
    );
  end

  assign out_valid = vld_q;
  assign out_l     = ch_out[0];
  assign out_r     = ch_out[1];

endmodule

// File: rtl/conceal_chk.sv
module conceal_chk #(
  parameter int W        = 16,
  parameter int ZC_LIMIT = 1024
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         mute_req,
  input logic         zc_en,
  input logic         out_valid,
  input logic [W-1:0] out_l,
  input logic [W-1:0] out_r
);

  logic [1:0]  seen_q;
  logic [31:0] req_run_q;
  logic        beat;

  assign beat = in_valid && (seen_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 2'd0;
      req_run_q <= '0;
    end else begin
      if (in_valid && (seen_q != 2'd2)) seen_q <= seen_q + 2'd1;
      if (beat) begin
        if (!mute_req) req_run_q <= '0;
        else if (req_run_q < 32'(ZC_LIMIT)) req_run_q <= req_run_q + 32'd1;
      end
    end
  end

  // R1: strobe follows each decision beat
  a_r1_strobe_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> out_valid);

  // R1: no strobe without a decision beat
  a_r1_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> !out_valid);

  // R11: outputs hold between beats
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_l) && $stable(out_r)));

  // R8: immediate mute zeroes both channels
  a_r8_direct_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mute_req && !zc_en) |=> ((out_l == '0) && (out_r == '0)));

  // R10: the wait for a crossing is bounded
  a_r10_zc_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mute_req && (req_run_q >= 32'(ZC_LIMIT - 1)))
      |=> ((out_l == '0) && (out_r == '0)));

endmodule

bind conceal_top conceal_chk #(
  .W        (W),
  .ZC_LIMIT (ZC_LIMIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mute_req  (mute_req),
  .zc_en     (zc_en),
  .out_valid (out_valid),
  .out_l     (out_l),
  .out_r     (out_r)
);

// File: tb/sim_conceal_top.sv
`timescale 1ns/1ps
module sim_conceal_top;

  localparam int W        = 16;
  localparam int MUTE_RUN = 8;
  localparam int ZC_LIMIT = 1024;
  localparam int NB       = 1640;
  localparam int DEPTH    = 2048;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_l, in_r;
  logic         in_err_l, in_err_r;
  logic         mute_req, zc_en;
  logic         out_valid;
  logic [W-1:0] out_l, out_r;

  int  n_chk;
  int  n_err;
  bit  done;

  int  sv [2][DEPTH];
  bit  fe [2][DEPTH];
  bit  mq [DEPTH];
  bit  zq [DEPTH];

  bit  m_muted [2];
  int  m_wait  [2];
  bit  m_neg   [2];

  conceal_top #(.W(W), .MUTE_RUN(MUTE_RUN), .ZC_LIMIT(ZC_LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_l(in_l), .in_r(in_r), .in_err_l(in_err_l), .in_err_r(in_err_r),
    .mute_req(mute_req), .zc_en(zc_en),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // concealed value from the requirements (R3..R6), by scanning the history
  function automatic int conceal_ref(input int ch, input int n, output string tag);
    int run;
    int good;
    run  = 0;
    good = 0;
    if (!fe[ch][n]) begin
      tag = "R3";
      return sv[ch][n];
    end
    for (int j = n; j >= 0; j--) begin
      if (!fe[ch][j]) break;
      run++;
    end
    for (int j = n - 1; j >= 0; j--) begin
      if (!fe[ch][j]) begin
        good = sv[ch][j];
        break;
      end
    end
    if (run >= MUTE_RUN) begin
      tag = "R6";
      return 0;
    end
    if (run >= 2 || fe[ch][n+1]) begin
      tag = "R5";
      return good;
    end
    tag = "R4";
    return (good + sv[ch][n+1]) >>> 1;
  endfunction

  // mute stage model (R8..R10)
  function automatic int mute_ref(input int ch, input int cand, input int k, inout string tag);
    int  res;
    bit  neg;
    bit  crossed;
    neg = (cand < 0);
    if (!mq[k]) begin
      m_muted[ch] = 1'b0;
      m_wait[ch]  = 0;
      res = cand;
    end else if (!zq[k]) begin
      m_muted[ch] = 1'b1;
      m_wait[ch]  = 0;
      res = 0;
      tag = "R8";
    end else if (m_muted[ch]) begin
      res = 0;
      tag = "R9";
    end else begin
      crossed = (cand == 0) || (neg != m_neg[ch]);
      if (crossed) begin
        m_muted[ch] = 1'b1;
        m_wait[ch]  = 0;
        res = 0;
        tag = "R9";
      end else if (m_wait[ch] == ZC_LIMIT - 1) begin
        m_muted[ch] = 1'b1;
        m_wait[ch]  = 0;
        res = 0;
        tag = "R10";
      end else begin
        m_wait[ch]++;
        res = cand;
        tag = "R9";
      end
    end
    m_neg[ch] = neg;
    return res;
  endfunction

  // stimulus tables
  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    for (int n = 0; n < DEPTH; n++) begin
      for (int c = 0; c < 2; c++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        sv[c][n] = $signed(seed[30:15]);
        fe[c][n] = 1'b0;
      end
      mq[n] = 1'b0;
      zq[n] = 1'b0;
      if (n < 398) begin
        fe[0][n] = (n % 11 == 4) || (n == 1) || (n % 37 == 20) || (n % 37 == 21) ||
                   (n % 53 >= 30 && n % 53 <= 32) || (n >= 300 && n <= 311);
        fe[1][n] = (n % 7 == 2) || (n == 0) || (n % 41 == 5) || (n % 41 == 6) ||
                   (n >= 150 && n <= 159);
      end
      if (n >= 470 && n < 525) sv[0][n] = 100 + (n - 470);
      if (n >= 525 && n < 570) sv[0][n] = -(n - 500);
      if (n >= 470 && n < 540) sv[1][n] = -500;
      if (n >= 540 && n < 545) sv[1][n] = 0;
      if (n >= 545 && n < 570) sv[1][n] = -300;
      if (n >= 570) begin
        sv[0][n] = 1000;
        sv[1][n] = 2000;
      end
      if (n >= 430 && n <= 439) mq[n] = 1'b1;
      if (n >= 480 && n <= 560) begin
        mq[n] = 1'b1;
        zq[n] = 1'b1;
      end
      if (n >= 580 && n <= 1610) begin
        mq[n] = 1'b1;
        zq[n] = 1'b1;
      end
    end
    // full-scale and rounding corners
    sv[0][400] = 32767;  sv[0][401] = 5;  fe[0][401] = 1'b1; sv[0][402] = 32767;
    sv[0][403] = -32768; sv[0][404] = 5;  fe[0][404] = 1'b1; sv[0][405] = -32768;
    sv[0][406] = 32767;  sv[0][407] = 5;  fe[0][407] = 1'b1; sv[0][408] = -32768;
    sv[1][400] = -1;     sv[1][401] = 77; fe[1][401] = 1'b1; sv[1][402] = 0;
  end

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    string tl, tr;
    int    el, er;
    int    hl, hr;
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    for (int c = 0; c < 2; c++) begin
      m_muted[c] = 1'b0;
      m_wait[c]  = 0;
      m_neg[c]   = 1'b0;
    end
    rst_n = 1'b0; in_valid = 1'b0; in_l = '0; in_r = '0;
    in_err_l = 1'b0; in_err_r = 1'b0; mute_req = 1'b0; zc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 out_valid in reset", int'(out_valid), 0);
    chk("R2 out_l in reset", int'(out_l), 0);
    chk("R2 out_r in reset", int'(out_r), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 out_valid after reset", int'(out_valid), 0);
    chk("R2 out_l after reset", int'(out_l), 0);

    for (int k = 0; k < NB; k++) begin
      in_valid = 1'b1;
      in_l = sv[0][k][15:0];  in_r = sv[1][k][15:0];
      in_err_l = fe[0][k];    in_err_r = fe[1][k];
      mute_req = mq[k];       zc_en = zq[k];
      @(negedge clk);
      in_valid = 1'b0;
      if (k < 2) begin
        chk("R1 no strobe while filling", int'(out_valid), 0);
      end else begin
        el = conceal_ref(0, k - 2, tl);
        er = conceal_ref(1, k - 2, tr);
        el = mute_ref(0, el, k, tl);
        er = mute_ref(1, er, k, tr);
        if (fe[0][k-2] != fe[1][k-2]) begin
          tl = {tl, "/R7"};
          tr = {tr, "/R7"};
        end
        chk("R1 strobe after beat", int'(out_valid), 1);
        chk($sformatf("%s left sample %0d", tl, k - 2), int'($signed(out_l)), el);
        chk($sformatf("%s right sample %0d", tr, k - 2), int'($signed(out_r)), er);
      end
      hl = int'(out_l);
      hr = int'(out_r);
      @(negedge clk);
      chk("R1 strobe is one cycle", int'(out_valid), 0);
      chk("R11 left held between beats", int'(out_l), hl);
      chk("R11 right held between beats", int'(out_r), hr);
    end
    finish_run();
  end

endmodule